// File: doc/BRIEF.md
# Interleaved Two-Bank Video Memory Address Mapper

This block sits between a requester that thinks of video memory as one linear 8 MB byte space and a memory built as two 32-bit banks of 4 MB each. Consecutive 32-bit words of the linear space alternate between the banks: even words live in bank 0 and odd words in bank 1, each bank indexed by the word-pair number. A request gives a start byte address, a byte count and a write flag. The mapper breaks it into one beat per bank word, with the bank select, the word index within that bank and a byte-enable mask.

A second request kind moves a rectangle. It carries a line length, a line pitch and a line count. After each line the unused part of the pitch is skipped, so a 2-D image can be written into a wider frame. Write data is not buffered. The requester presents the data for the current beat on `wr_data`, and that data is passed straight through to the bank side together with the beat. A `done` pulse tells the requester that the whole transfer has been handed off.

Top module: `vram_ilv_mapper`

## Requirements
- R1: A linear transfer whose start address plus byte count would pass the end of the 8 MB window (byte 0x7FFFFF) is cut short, so that its last byte is 0x7FFFFF. No beat is issued for any address beyond that byte.
- R2: Every beat addresses the word that holds its bytes. `beat_bank` is bit 2 of the byte address and `beat_widx` is bits 22:3 of that address.
- R3: When the start address is not word aligned, the first beat carries only the requested bytes of that word. `beat_be` bit i stands for byte i of the word (address bits 1:0 equal to i), so the mask starts at the start offset. The next beat uses the other bank.
- R4: A full word beat has `beat_be` = 4'b1111. Within a line, consecutive beats alternate banks. `beat_widx` increases by one after each bank-1 beat and stays the same after each bank-0 beat.
- R5: Trailing bytes that do not fill a word go out as one last beat with enables for only the low bytes of that word.
- R6: In strided mode (`req_strided` = 1), line k starts at start + k × `req_stride`. Each line moves `req_len` bytes, and addresses wrap modulo 8 MB. The start address, the line length and the pitch must be multiples of 4, and the pitch must not be smaller than the line length.
- R7: A beat is handed off on every cycle in which both `beat_valid` and `beat_ready` are high. While `beat_ready` is low, the offered beat stays unchanged.
- R8: `beat_last` marks the final beat of a transfer. `done` is high for exactly the one cycle after that beat is handed off, and in that cycle no beat is offered.
- R9: A request with zero bytes, or a strided request with zero lines, issues no beat. Its `done` pulse comes in the cycle after the request is accepted.
- R10: `req_ready` is high exactly when no transfer is in progress. `beat_write` repeats the write flag of the request, and `beat_wdata` equals `wr_data` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Mapper idle; request accepted on valid and ready |
| req_addr | input | ADDR_W (23) | Start byte address in the window |
| req_len | input | LEN_W (24) | Byte count (linear) or line length in bytes (strided) |
| req_write | input | 1 | Transfer direction, 1 = write |
| req_strided | input | 1 | Selects the strided rectangle mode |
| req_stride | input | LEN_W (24) | Line pitch in bytes (strided mode) |
| req_lines | input | LINE_W (10) | Number of lines (strided mode) |
| wr_data | input | DATA_W (32) | Write data for the beat now offered |
| beat_valid | output | 1 | Beat offered to the banks |
| beat_ready | input | 1 | Bank side accepts the beat |
| beat_bank | output | 1 | Selected bank |
| beat_widx | output | ADDR_W-3 (20) | Word index within the bank |
| beat_be | output | 4 | Byte enables, bit i = byte i of the word |
| beat_write | output | 1 | Direction of the beat |
| beat_wdata | output | DATA_W (32) | Write data passed through |
| beat_last | output | 1 | Final beat of the transfer |
| done | output | 1 | One-cycle transfer completion pulse |

## Verification
The bench builds the block with its default parameters: a 23-bit window, a 24-bit byte count, a 10-bit line count and the strided variant enabled. The 24-bit count lets a single request reach well past the end of the window, so the cut-off at the top of memory can be driven directly. Because the window is full size, strided requests placed near the top wrap around to low addresses. Random ready stalls exercise the hold rule, and full-rate runs measure one beat per cycle.

// File: rtl/vmap_pkg.sv
package vmap_pkg;

   localparam int WORD_BYTES = 4;
   localparam int BE_W       = WORD_BYTES;

   // Byte-enable mask covering n bytes starting at byte offset off
   function automatic logic [BE_W-1:0] be_span(input logic [1:0] off, input logic [2:0] n);
      logic [BE_W-1:0] m;
      logic [2:0]      lo;
      logic [2:0]      hi;
      lo = {1'b0, off};
      hi = lo + n;
      for (int i = 0; i < BE_W; i++) begin
         m[i] = (3'(i) >= lo) && (3'(i) < hi);
      end
      return m;
   endfunction

endpackage

// File: rtl/vmap_req_decode.sv
module vmap_req_decode #(
   parameter int ADDR_W    = 23,
   parameter int LEN_W     = 24,
   parameter int LINE_W    = 10,
   parameter bit STRIDE_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   input  logic              strided,
   input  logic [LEN_W-1:0]  stride,
   input  logic [LINE_W-1:0] lines,
   output logic [ADDR_W-1:0] start_p,
   output logic [LEN_W-1:0]  line_len,
   output logic [LEN_W-1:0]  gap,
   output logic [LINE_W-1:0] line_cnt,
   output logic              empty
);
   localparam int CMP_W = (LEN_W > ADDR_W + 1) ? LEN_W : ADDR_W + 1;

   logic [ADDR_W:0]  room;
   logic [LEN_W-1:0] lin_len;

   // bytes left from the start address up to the window end
   assign room    = (ADDR_W+1)'(1) << ADDR_W;
   assign lin_len = (CMP_W'(len) > CMP_W'(room - {1'b0, addr})) ?
                    LEN_W'(room - {1'b0, addr}) : len;
   assign start_p = addr;

   generate
      if (STRIDE_EN) begin : g_stride
         always_comb begin
            if (strided) begin
               line_len = len;
               gap      = stride - len;
               line_cnt = lines;
               empty    = (len == '0) || (lines == '0);
            end else begin
               line_len = lin_len;
               gap      = '0;
               line_cnt = LINE_W'(1);
               empty    = (lin_len == '0);
            end
         end
      end else begin : g_linear
         assign line_len = lin_len;
         assign gap      = '0;
         assign line_cnt = LINE_W'(1);
         assign empty    = (lin_len == '0);
      end
   endgenerate

endmodule

// File: rtl/vmap_beat_calc.sv
module vmap_beat_calc
   import vmap_pkg::*;
#(
   parameter int ADDR_W = 23,
   parameter int LEN_W  = 24
) (
   input  logic [ADDR_W-1:0]   p,
   input  logic [LEN_W-1:0]    rem,
   output logic                bank,
   output logic [ADDR_W-4:0]   widx,
   output logic [BE_W-1:0]     be,
   output logic [2:0]          nbytes,
   output logic                line_end
);
   logic [2:0] avail;

   assign avail    = 3'd4 - {1'b0, p[1:0]};
   assign nbytes   = (rem < LEN_W'(avail)) ? rem[2:0] : avail;
   assign be       = be_span(p[1:0], nbytes);
   assign bank     = p[2];
   assign widx     = p[ADDR_W-1:3];
   assign line_end = (rem == LEN_W'(nbytes));

endmodule

// File: rtl/vmap_seq.sv
module vmap_seq #(
   parameter int ADDR_W = 23,
   parameter int LEN_W  = 24,
   parameter int LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] start_p,
   input  logic [LEN_W-1:0]  line_len_in,
   input  logic [LEN_W-1:0]  gap_in,
   input  logic [LINE_W-1:0] line_cnt_in,
   input  logic              empty,
   input  logic              beat_ready,
   input  logic [2:0]        nbytes,
   input  logic              line_end,
   output logic              busy,
   output logic              done,
   output logic              wr_q,
   output logic              last_line,
   output logic [ADDR_W-1:0] p,
   output logic [LEN_W-1:0]  rem
);
   localparam int SUM_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;

   logic [LEN_W-1:0]  line_len_q;
   logic [LEN_W-1:0]  gap_q;
   logic [LINE_W-1:0] lines_left;
   logic [SUM_W-1:0]  next_line_p;

   assign next_line_p = SUM_W'(p) + SUM_W'(nbytes) + SUM_W'(gap_q);
   assign last_line   = (lines_left == LINE_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         done       <= 1'b0;
         wr_q       <= 1'b0;
         p          <= '0;
         rem        <= '0;
         line_len_q <= '0;
         gap_q      <= '0;
         lines_left <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (req_valid) begin
               wr_q       <= req_write;
               p          <= start_p;
               rem        <= line_len_in;
               line_len_q <= line_len_in;
               gap_q      <= gap_in;
               lines_left <= line_cnt_in;
               if (empty) begin
                  done <= 1'b1;
               end else begin
                  busy <= 1'b1;
               end
            end
         end else if (beat_ready) begin
            if (line_end) begin
               if (last_line) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  p          <= ADDR_W'(next_line_p);
                  rem        <= line_len_q;
                  lines_left <= lines_left - LINE_W'(1);
               end
            end else begin
               p   <= p + ADDR_W'(nbytes);
               rem <= rem - LEN_W'(nbytes);
            end
         end
      end
   end

endmodule

// File: rtl/vram_ilv_mapper.sv
module vram_ilv_mapper
   import vmap_pkg::*;
#(
   parameter int ADDR_W    = 23,
   parameter int LEN_W     = 24,
   parameter int LINE_W    = 10,
   parameter int DATA_W    = 32,
   parameter bit STRIDE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_write,
   input  logic              req_strided,
   input  logic [LEN_W-1:0]  req_stride,
   input  logic [LINE_W-1:0] req_lines,
   input  logic [DATA_W-1:0] wr_data,
   output logic              beat_valid,
   input  logic              beat_ready,
   output logic              beat_bank,
   output logic [ADDR_W-4:0] beat_widx,
   output logic [3:0]        beat_be,
   output logic              beat_write,
   output logic [DATA_W-1:0] beat_wdata,
   output logic              beat_last,
   output logic              done
);
   localparam int WIDX_W = ADDR_W - 3;

   generate
      if (DATA_W != 8 * WORD_BYTES) begin : g_bad_data
         $error("vram_ilv_mapper: DATA_W must equal one bank word");
      end
      if (ADDR_W < 4 || ADDR_W > 30) begin : g_bad_addr
         $error("vram_ilv_mapper: ADDR_W out of range");
      end
      if (LEN_W < 3 || LINE_W < 1) begin : g_bad_len
         $error("vram_ilv_mapper: LEN_W or LINE_W too small");
      end
   endgenerate

   logic [ADDR_W-1:0] start_p;
   logic [LEN_W-1:0]  line_len;
   logic [LEN_W-1:0]  gap;
   logic [LINE_W-1:0] line_cnt;
   logic              empty;
   logic              busy;
   logic              wr_q;
   logic              last_line;
   logic [ADDR_W-1:0] cur_p;
   logic [LEN_W-1:0]  cur_rem;
   logic [2:0]        nbytes;
   logic              cur_line_end;
   logic [WIDX_W-1:0] widx;

   vmap_req_decode #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_W(LINE_W), .STRIDE_EN(STRIDE_EN)
   ) u_dec (
      .addr(req_addr), .len(req_len), .strided(req_strided),
      .stride(req_stride), .lines(req_lines),
      .start_p(start_p), .line_len(line_len), .gap(gap),
      .line_cnt(line_cnt), .empty(empty)
   );

   vmap_seq #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_W(LINE_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .start_p(start_p), .line_len_in(line_len), .gap_in(gap),
      .line_cnt_in(line_cnt), .empty(empty), .beat_ready(beat_ready),
      .nbytes(nbytes), .line_end(cur_line_end), .busy(busy), .done(done),
      .wr_q(wr_q), .last_line(last_line), .p(cur_p), .rem(cur_rem)
   );

   vmap_beat_calc #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W)
   ) u_calc (
      .p(cur_p), .rem(cur_rem), .bank(beat_bank), .widx(widx),
      .be(beat_be), .nbytes(nbytes), .line_end(cur_line_end)
   );

   assign beat_widx  = widx;
   assign req_ready  = !busy;
   assign beat_valid = busy;
   assign beat_last  = cur_line_end && last_line;
   assign beat_write = wr_q;
   assign beat_wdata = wr_data;

endmodule

// File: rtl/vmap_chk.sv
module vmap_chk #(
   parameter int WIDX_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              beat_valid,
   input logic              beat_ready,
   input logic              beat_bank,
   input logic [WIDX_W-1:0] beat_widx,
   input logic [3:0]        beat_be,
   input logic              beat_last,
   input logic              done,
   input logic              line_end
);
   logic fire;
   assign fire = beat_valid && beat_ready;

   AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && !beat_ready |=> beat_valid && $stable(beat_bank) && $stable(beat_widx)
                                    && $stable(beat_be) && $stable(beat_last)); // R7
   AST_BE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> beat_be != 4'b0000); // R3
   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> !req_ready); // R10
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      fire && beat_last |=> done && !beat_valid); // R8
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !beat_valid && req_ready); // R8
   AST_BANK_ALT: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !line_end |=> beat_valid && (beat_bank != $past(beat_bank))); // R4
   AST_WIDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !line_end && beat_bank |=> beat_widx == $past(beat_widx) + WIDX_W'(1)); // R4
   AST_WIDX_SAME: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !line_end && !beat_bank |=> beat_widx == $past(beat_widx)); // R2

endmodule

bind vram_ilv_mapper vmap_chk #(.WIDX_W(WIDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .beat_valid(beat_valid),
   .beat_ready(beat_ready), .beat_bank(beat_bank), .beat_widx(beat_widx),
   .beat_be(beat_be), .beat_last(beat_last), .done(done), .line_end(cur_line_end)
);

// File: tb/sim_vram_ilv_mapper.sv
module sim_vram_ilv_mapper;
   localparam int AW = 23;
   localparam int LW = 24;
   localparam int NW = 10;
   localparam int DW = 32;
   localparam int XW = AW - 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic          req_ready;
   logic [AW-1:0] req_addr;
   logic [LW-1:0] req_len;
   logic          req_write;
   logic          req_strided;
   logic [LW-1:0] req_stride;
   logic [NW-1:0] req_lines;
   logic [DW-1:0] wr_data;
   logic          beat_valid;
   logic          beat_ready;
   logic          beat_bank;
   logic [XW-1:0] beat_widx;
   logic [3:0]    beat_be;
   logic          beat_write;
   logic [DW-1:0] beat_wdata;
   logic          beat_last;
   logic          done;

   always #10 clk = ~clk;

   vram_ilv_mapper u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
      .req_strided(req_strided), .req_stride(req_stride), .req_lines(req_lines),
      .wr_data(wr_data), .beat_valid(beat_valid), .beat_ready(beat_ready),
      .beat_bank(beat_bank), .beat_widx(beat_widx), .beat_be(beat_be),
      .beat_write(beat_write), .beat_wdata(beat_wdata), .beat_last(beat_last),
      .done(done)
   );

   int total = 0;
   int bad   = 0;
   int exp_word [0:4095];
   logic [3:0] exp_be [0:4095];
   int nexp;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   // group bytes into word beats, one byte at a time
   task automatic add_byte(input int b);
      int w;
      w = b >> 2;
      if (nexp > 0 && exp_word[nexp-1] == w) begin
         exp_be[nexp-1][b & 3] = 1'b1;
      end else begin
         exp_word[nexp] = w;
         exp_be[nexp] = 4'b0000;
         exp_be[nexp][b & 3] = 1'b1;
         nexp++;
      end
   endtask

   task automatic build(input int addr, input int len, input bit strided,
                        input int stride, input int lines);
      int a;
      int l;
      nexp = 0;
      a = addr & 32'h7FFFFF;
      if (!strided) begin
         l = len;
         if (a + l > 32'h800000) l = 32'h800000 - a;   // R1 window end
         for (int i = 0; i < l; i++) add_byte(a + i);
      end else begin
         for (int k = 0; k < lines; k++)
            for (int i = 0; i < len; i++)
               add_byte((a + k * stride + i) & 32'h7FFFFF);   // R6
      end
   endtask

   task automatic run(input int addr, input int len, input bit wr, input bit strided,
                      input int stride, input int lines, input int rdy_pct, input string tag);
      int got;
      int cyc;
      logic exp_bank;
      logic [XW-1:0] exp_widx;
      string betag;
      build(addr, len, strided, stride, lines);
      chk(req_ready === 1'b1, "R10", "ready while idle", req_ready, 1);
      req_addr    = AW'(addr);
      req_len     = LW'(len);
      req_write   = wr;
      req_strided = strided;
      req_stride  = LW'(stride);
      req_lines   = NW'(lines);
      req_valid   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      got = 0;
      cyc = 0;
      while (got < nexp && cyc < 4000) begin
         beat_ready = (($urandom % 100) < rdy_pct);
         wr_data    = $urandom;
         #1;
         if (beat_valid === 1'b1 && beat_ready) begin
            exp_bank = exp_word[got][0];
            exp_widx = XW'(exp_word[got] >> 1);
            chk(beat_bank === exp_bank && beat_widx === exp_widx, tag, "bank/word",
                {beat_bank, beat_widx}, {exp_bank, exp_widx});
            if (got == 0 && (addr & 3) != 0) betag = "R3";
            else if (exp_be[got] == 4'hF) betag = "R4";
            else betag = "R5";
            chk(beat_be === exp_be[got], betag, "byte enables", beat_be, exp_be[got]);
            chk(beat_last === (got == nexp - 1), "R8", "last flag", beat_last, (got == nexp - 1));
            chk(beat_write === wr && beat_wdata === wr_data, "R10", "write pass-through",
                {beat_write, beat_wdata}, {wr, wr_data});
            got++;
         end
         cyc++;
         @(negedge clk);
      end
      beat_ready = 1'b0;
      if (got < nexp) chk(1'b0, "R7", "beats delivered", got, nexp);
      if (rdy_pct == 100) chk(cyc == nexp, "R7", "cycles at full rate", cyc, nexp);
      if (nexp == 0) chk(done === 1'b1 && beat_valid === 1'b0, "R9", "empty done", {done, beat_valid}, 2);
      else           chk(done === 1'b1 && beat_valid === 1'b0, "R8", "done after last", {done, beat_valid}, 2);
      @(negedge clk);
      chk(done === 1'b0, "R8", "done one cycle", done, 0);
   endtask

   initial begin
      #3000000;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0; req_valid = 1'b0; beat_ready = 1'b0; wr_data = '0;
      req_addr = '0; req_len = '0; req_write = 1'b0; req_strided = 1'b0;
      req_stride = '0; req_lines = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(beat_valid === 1'b0 && done === 1'b0, "R8", "reset outputs", {beat_valid, done}, 0);
      chk(req_ready === 1'b1, "R10", "reset ready", req_ready, 1);

      run(32'h100, 16, 1, 0, 0, 0, 100, "R2");          // aligned words
      run(32'h103, 7, 0, 0, 0, 0, 60, "R2");            // head + tail
      run(32'h101, 2, 1, 0, 0, 0, 100, "R2");           // inside one word
      run(32'h7FFFFB, 20, 1, 0, 0, 0, 100, "R1");       // cut at window end
      run(32'h7FFFF0, 16, 0, 0, 0, 0, 50, "R1");        // ends exactly at top
      run(32'h40, 0, 1, 0, 0, 0, 100, "R9");            // zero bytes
      run(32'h40, 8, 1, 1, 20, 0, 100, "R9");           // zero lines
      run(32'h40, 8, 1, 1, 20, 3, 100, "R6");           // gap with odd word
      run(32'h7FFFF8, 8, 1, 1, 16, 2, 100, "R6");       // wrap to bottom
      run(32'h204, 12, 0, 1, 12, 3, 40, "R6");          // pitch equals length

      for (int t = 0; t < 40; t++) begin
         int a;
         a = $urandom & 32'h7FFFFF;
         if ($urandom % 4 == 0) a = 32'h800000 - ($urandom % 40) - 1;
         run(a, $urandom % 65, $urandom % 2, 0, 0, 0, 30 + $urandom % 71, "R2");
      end
      for (int t = 0; t < 20; t++) begin
         int a;
         int l;
         a = ($urandom & 32'h7FFFFF) & ~32'd3;
         l = 4 * ($urandom % 6);
         run(a, l, $urandom % 2, 1, l + 4 * ($urandom % 5), $urandom % 5,
             30 + $urandom % 71, "R6");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule